// File: doc/BRIEF.md
# Serial Time-Slot Window Generator

This block tells a serial HDLC channel which bits of a framed PCM stream belong to it. A bit counter is restarted by a one-cycle frame sync strobe that marks bit zero of each frame. For each direction, receive and transmit, a window opens at a programmed bit offset and stays open for a programmed number of bits. Downstream framing logic shifts a bit only while its enable is high.

The offset of each direction is a 9-bit value. A coarse 6-bit slot number selects an 8-bit slot and a 3-bit shift moves the window by single bits inside it. The length of each window is given as length minus one, so the range is 1 to 256 bits. The transmit path also drives an active-low clock gate that is low for the whole transmit window. The transmit enable is further qualified by a clear-to-send input, and dropping that input silences the transmitter in the same bit.

The frame length itself is not programmed. The next frame sync cuts off any window that is still open, so a slot placed past the end of the frame never appears.

Top module: `ts_slot_window_gen`

## Requirements
- R1: The cycle in which frame_sync is high is bit 0 of the frame, and each later clock cycle is the next bit position.
- R2: A direction's window opens at bit position slot_num*8 + bit_shift. The slot number forms the upper 6 bits and the shift forms the lower 3 bits of the 9-bit start position.
- R3: A window stays open for len_m1+1 consecutive bits. A length code of 0 gives a 1-bit window and 255 gives a 256-bit window.
- R4: The receive and transmit windows are computed from their own slot, shift and length inputs, and each window ignores the other direction's settings.
- R5: tx_clk_gate_n is low in every bit of the transmit window and high in every other bit, whatever the state of clr_to_send.
- R6: tx_bit_en is high exactly when the transmit window is open and clr_to_send is high in the same cycle. Deasserting clr_to_send mid-window drops tx_bit_en in that same bit.
- R7: A frame_sync arriving while a window is open closes that window at the new bit 0, unless the window starts at bit 0. A window that starts at or beyond the next frame sync never opens.
- R8: After reset, and until the first frame_sync, rx_bit_en and tx_bit_en are low and tx_clk_gate_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one cycle per serial bit |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | One-cycle strobe marking bit 0 of a frame |
| rx_slot_num | input | 6 | Receive coarse slot number (8-bit units) |
| rx_bit_shift | input | 3 | Receive fine offset in bits |
| rx_len_m1 | input | 8 | Receive window length minus one |
| tx_slot_num | input | 6 | Transmit coarse slot number (8-bit units) |
| tx_bit_shift | input | 3 | Transmit fine offset in bits |
| tx_len_m1 | input | 8 | Transmit window length minus one |
| clr_to_send | input | 1 | Clear-to-send, active high |
| rx_bit_en | output | 1 | High in each bit of the receive window |
| tx_bit_en | output | 1 | High in each transmit window bit while clear-to-send is high |
| tx_clk_gate_n | output | 1 | Low throughout the transmit window, high otherwise |

## Verification
Some behaviours are checked on every cycle. The transmit enable must always equal the transmit window gated by clear-to-send. Every rising receive window and every falling transmit gate must land on the programmed start bit, counted from the last sync. An open window must be cut at a sync unless it starts at bit 0. Outputs must stay quiet between reset and the first sync. Other behaviours can only be shown by the bench's scenarios: the exact window length (1, 8 and 256 bits), truncation against a particular frame length, slots placed beyond the frame, and the two directions running with unrelated settings.

// File: rtl/ts_win_pkg.sv
package ts_win_pkg;

    // Field widths of the slot programming
    localparam int unsigned TS_SLOT_W  = 6;
    localparam int unsigned TS_SHIFT_W = 3;
    localparam int unsigned TS_LEN_W   = 8;
    localparam int unsigned TS_NUM_DIR = 2;
    localparam int unsigned TS_RX      = 0;
    localparam int unsigned TS_TX      = 1;

    // Derived widths: start spans slot+shift, last bit needs one extra bit
    localparam int unsigned TS_START_W = TS_SLOT_W + TS_SHIFT_W;
    localparam int unsigned TS_POS_W   =
        ((TS_START_W > TS_LEN_W) ? TS_START_W : TS_LEN_W) + 1;

    typedef logic [TS_POS_W-1:0] ts_pos_t;

    // Parked counter value: above any reachable last bit, so no window matches
    localparam ts_pos_t TS_POS_IDLE = '1;

    typedef struct packed {
        logic [TS_SLOT_W-1:0]  slot;
        logic [TS_SHIFT_W-1:0] shift;
        logic [TS_LEN_W-1:0]   len_m1;
    } ts_cfg_t;

    function automatic ts_pos_t ts_first_bit(input ts_cfg_t c);
        return ts_pos_t'({c.slot, c.shift});
    endfunction

    function automatic ts_pos_t ts_last_bit(input ts_cfg_t c);
        return ts_first_bit(c) + ts_pos_t'(c.len_m1);
    endfunction

endpackage

// File: rtl/ts_bit_counter.sv
module ts_bit_counter
    import ts_win_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    frame_sync,
    output ts_pos_t bit_pos
);

    ts_pos_t cnt_q;

    // The sync bit is bit 0 in its own cycle, with no register delay
    assign bit_pos = frame_sync ? '0 : cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= TS_POS_IDLE;
        end else if (bit_pos != TS_POS_IDLE) begin
            cnt_q <= bit_pos + 1'b1;
        end
    end

endmodule

// File: rtl/ts_window.sv
module ts_window
    import ts_win_pkg::*;
(
    input  ts_pos_t bit_pos,
    input  ts_cfg_t cfg,
    output logic    active
);

    ts_pos_t first_bit;
    ts_pos_t last_bit;

    always_comb begin
        first_bit = ts_first_bit(cfg);
        last_bit  = ts_last_bit(cfg);
        active    = (bit_pos >= first_bit) && (bit_pos <= last_bit);
    end

endmodule

// File: rtl/ts_tx_gate.sv
module ts_tx_gate (
    input  logic tx_window,
    input  logic clr_to_send,
    output logic tx_bit_en,
    output logic tx_clk_gate_n
);

    always_comb begin
        tx_clk_gate_n = ~tx_window;
        tx_bit_en     = tx_window & clr_to_send;
    end

endmodule

// File: rtl/ts_slot_window_gen.sv
module ts_slot_window_gen
    import ts_win_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_sync,
    input  logic [5:0] rx_slot_num,
    input  logic [2:0] rx_bit_shift,
    input  logic [7:0] rx_len_m1,
    input  logic [5:0] tx_slot_num,
    input  logic [2:0] tx_bit_shift,
    input  logic [7:0] tx_len_m1,
    input  logic       clr_to_send,
    output logic       rx_bit_en,
    output logic       tx_bit_en,
    output logic       tx_clk_gate_n
);

    ts_pos_t                bit_pos;
    ts_cfg_t                dir_cfg [TS_NUM_DIR];
    logic [TS_NUM_DIR-1:0]  dir_win;

    assign dir_cfg[TS_RX] = '{slot: rx_slot_num, shift: rx_bit_shift, len_m1: rx_len_m1};
    assign dir_cfg[TS_TX] = '{slot: tx_slot_num, shift: tx_bit_shift, len_m1: tx_len_m1};

    ts_bit_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (frame_sync),
        .bit_pos    (bit_pos)
    );

    for (genvar d = 0; d < TS_NUM_DIR; d++) begin : g_dir
        ts_window u_win (
            .bit_pos (bit_pos),
            .cfg     (dir_cfg[d]),
            .active  (dir_win[d])
        );
    end

    assign rx_bit_en = dir_win[TS_RX];

    ts_tx_gate u_txg (
        .tx_window     (dir_win[TS_TX]),
        .clr_to_send   (clr_to_send),
        .tx_bit_en     (tx_bit_en),
        .tx_clk_gate_n (tx_clk_gate_n)
    );

endmodule

// File: rtl/ts_slot_window_chk.sv
module ts_slot_window_chk
    import ts_win_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       frame_sync,
    input logic [5:0] rx_slot_num,
    input logic [2:0] rx_bit_shift,
    input logic [5:0] tx_slot_num,
    input logic [2:0] tx_bit_shift,
    input logic       clr_to_send,
    input logic       rx_bit_en,
    input logic       tx_bit_en,
    input logic       tx_clk_gate_n
);

    logic    seen_sync_q;
    ts_pos_t cnt_q;
    ts_pos_t pos;
    ts_pos_t rx_start;
    ts_pos_t tx_start;

    assign pos      = frame_sync ? '0 : cnt_q;
    assign rx_start = ts_pos_t'({rx_slot_num, rx_bit_shift});
    assign tx_start = ts_pos_t'({tx_slot_num, tx_bit_shift});

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_sync_q <= 1'b0;
            cnt_q       <= TS_POS_IDLE;
        end else begin
            if (frame_sync) seen_sync_q <= 1'b1;
            if (pos != TS_POS_IDLE) cnt_q <= pos + 1'b1;
        end
    end

    // R2
    rx_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_bit_en) |-> (pos == rx_start));

    // R2
    tx_start_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_clk_gate_n) |-> (pos == tx_start));

    // R6
    tx_en_gated_chk: assert property (@(posedge clk) disable iff (rst)
        tx_bit_en |-> (!tx_clk_gate_n && clr_to_send));

    // R6
    tx_en_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_clk_gate_n && clr_to_send) |-> tx_bit_en);

    // R7
    sync_cut_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_sync && (rx_start != '0)) |-> !rx_bit_en);

    // R8
    quiet_before_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (!seen_sync_q && !frame_sync) |-> (!rx_bit_en && !tx_bit_en && tx_clk_gate_n));

endmodule

bind ts_slot_window_gen ts_slot_window_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .frame_sync    (frame_sync),
    .rx_slot_num   (rx_slot_num),
    .rx_bit_shift  (rx_bit_shift),
    .tx_slot_num   (tx_slot_num),
    .tx_bit_shift  (tx_bit_shift),
    .clr_to_send   (clr_to_send),
    .rx_bit_en     (rx_bit_en),
    .tx_bit_en     (tx_bit_en),
    .tx_clk_gate_n (tx_clk_gate_n)
);

// File: tb/sim_ts_slot_window_gen.sv
module sim_ts_slot_window_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_sync = 1'b0;
    logic [5:0] rx_slot_num = '0;
    logic [2:0] rx_bit_shift = '0;
    logic [7:0] rx_len_m1 = '0;
    logic [5:0] tx_slot_num = '0;
    logic [2:0] tx_bit_shift = '0;
    logic [7:0] tx_len_m1 = '0;
    logic       clr_to_send = 1'b1;
    logic       rx_bit_en;
    logic       tx_bit_en;
    logic       tx_clk_gate_n;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    ts_slot_window_gen u0 (
        .clk           (clk),
        .rst           (rst),
        .frame_sync    (frame_sync),
        .rx_slot_num   (rx_slot_num),
        .rx_bit_shift  (rx_bit_shift),
        .rx_len_m1     (rx_len_m1),
        .tx_slot_num   (tx_slot_num),
        .tx_bit_shift  (tx_bit_shift),
        .tx_len_m1     (tx_len_m1),
        .clr_to_send   (clr_to_send),
        .rx_bit_en     (rx_bit_en),
        .tx_bit_en     (tx_bit_en),
        .tx_clk_gate_n (tx_clk_gate_n)
    );

    // rx slot, rx shift, rx len-1, tx slot, tx shift, tx len-1, frame bits, CTS drop bit
    typedef struct packed {
        int rs; int rsh; int rl; int ts; int tsh; int tl; int flen; int cts_off;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{0,  0, 0,   0, 3, 7,   32,  1023}, // R3 1-bit rx, 8-bit tx
        '{2,  5, 7,   5, 0, 255, 400, 60},   // R3 256-bit tx, R6 CTS drop mid slot
        '{63, 7, 255, 1, 1, 0,   800, 1023}, // R2 highest start, R4 unrelated settings
        '{3,  0, 255, 0, 0, 255, 100, 1023}, // R7 both windows cut by next sync
        '{20, 0, 3,   7, 7, 15,  64,  0},    // R7 rx past frame, R5 gate without CTS
        '{4,  2, 31,  4, 2, 31,  128, 1023}  // R1 same position both ways
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit in_win(input int b, input int s, input int sh, input int l);
        return (b >= s * 8 + sh) && (b <= s * 8 + sh + l);
    endfunction

    task automatic run_vec(input vec_t v, input int idx);
        int rx_bad = 0;
        int txe_bad = 0;
        int gate_bad = 0;
        for (int f = 0; f < 2; f++) begin
            for (int b = 0; b < v.flen; b++) begin
                bit exp_rx, exp_tw, exp_cts;
                @(negedge clk);
                if (f == 0 && b == 0) begin
                    rx_slot_num  = 6'(v.rs);
                    rx_bit_shift = 3'(v.rsh);
                    rx_len_m1    = 8'(v.rl);
                    tx_slot_num  = 6'(v.ts);
                    tx_bit_shift = 3'(v.tsh);
                    tx_len_m1    = 8'(v.tl);
                end
                frame_sync  = (b == 0);
                exp_cts     = (b < v.cts_off);
                clr_to_send = exp_cts;
                #1;
                exp_rx = in_win(b, v.rs, v.rsh, v.rl);
                exp_tw = in_win(b, v.ts, v.tsh, v.tl);
                if (rx_bit_en !== exp_rx) rx_bad++;
                if (tx_bit_en !== (exp_tw && exp_cts)) txe_bad++;
                if (tx_clk_gate_n !== !exp_tw) gate_bad++;
            end
        end
        if (rx_bad != 0) $display("vector %0d rx mismatches", idx);
        check("R1/R2/R3/R4/R7 rx window bits wrong", rx_bad, 0);
        check("R6 tx enable bits wrong", txe_bad, 0);
        check("R5 tx clock gate bits wrong", gate_bad, 0);
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int bad;
        // Reset with windows programmed to start at bit 0
        rx_len_m1 = 8'd255;
        tx_len_m1 = 8'd255;
        repeat (3) @(negedge clk);
        #1;
        check("R8 reset state rx_bit_en", int'(rx_bit_en), 0);
        @(negedge clk);
        rst = 1'b0;
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            #1;
            if (rx_bit_en || tx_bit_en || !tx_clk_gate_n) bad++;
        end
        check("R8 outputs active before first sync", bad, 0);

        // Table walk
        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // Mid-window reset returns to the quiet state until a new sync
        @(negedge clk);
        rx_slot_num = '0; rx_bit_shift = '0; rx_len_m1 = 8'd255;
        tx_slot_num = '0; tx_bit_shift = '0; tx_len_m1 = 8'd255;
        clr_to_send = 1'b1;
        frame_sync  = 1'b1;
        @(negedge clk);
        frame_sync = 1'b0;
        repeat (5) @(negedge clk);
        #1;
        check("R3 window open mid frame", int'(rx_bit_en), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            #1;
            if (rx_bit_en || tx_bit_en || !tx_clk_gate_n) bad++;
        end
        check("R8 outputs active after mid-window reset", bad, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule